// File: doc/BRIEF.md
# DMA Channel Request Pacer

This block sequences one DMA channel when the channel itself owns the transfer length. Software presents an item count, a burst size and a direction, then raises the enable. The block watches the peripheral's burst and single request lines, or no lines at all for memory-to-memory work. It decides when the next bus transfer may begin and how many items that transfer moves. Each transfer goes to a separate bus master as a one-cycle start pulse with a length, and that master answers with a one-cycle done.

For peripheral-sourced traffic, the request line that is honoured depends on how much work is left. While at least one full burst remains, only the burst line starts a transfer. Below that point only the single line is honoured, and each single request moves one item. Memory-bound traffic toward a peripheral uses the burst line alone and trims the last burst to the leftover items. Memory-to-memory work issues transfers back to back until the count is used up or the enable is dropped.

A one-cycle clear goes back to the peripheral for each serviced request. When the final item lands, a one-cycle terminal-count pulse fires together with a completion pulse. A two-bit status shows the channel phase.

Top module: `dma_chan_pacer`

## Requirements
- R1: After reset, status is 0 (idle) and xfer_start, pclr, ptc and done_pulse are all low.
- R2: Raising cfg_enable while idle latches count, burst and direction, and status becomes 1 (waiting). A count of zero goes straight to status 3 with one done_pulse, and no transfer starts.
- R3: Direction 0 (peripheral to memory): while the remaining count is greater than or equal to the burst size, only preq_burst starts a transfer, with xfer_len equal to the burst size. preq_single is ignored. If both lines are high, the burst is taken.
- R4: Direction 0: while the remaining count is below the burst size, only preq_single starts a transfer, with xfer_len 1. preq_burst is ignored.
- R5: Direction 1 (memory to peripheral): only preq_burst starts a transfer, with xfer_len equal to the smaller of the remaining count and the burst size. A burst size of 1 gives single-item transfers.
- R6: Direction 2 (memory to memory): transfers of length min(remaining, burst) start back to back with no request, and pclr never pulses.
- R7: For directions 0 and 1, pclr is a one-cycle pulse in the same cycle as xfer_start. Request lines are ignored from then until xfer_done returns.
- R8: When xfer_done retires the last items, status becomes 3. done_pulse is a one-cycle pulse, and ptc is a one-cycle pulse at the same time for directions 0 and 1 only. Status 3 holds until cfg_enable is low, then returns to 0.
- R9: Dropping cfg_enable while waiting returns the block to idle on the next edge. Dropping it during a transfer lets that transfer finish, then the block goes to idle without ptc or done_pulse.
- R10: Status encoding is 0 idle, 1 waiting, 2 transferring, 3 complete. Direction code 3 is reserved and never starts a transfer.
- R11: A programmed burst size of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_dir | input | 2 | Direction code (0, 1, 2, 3 reserved) |
| cfg_count | input | CNT_W | Total item count |
| cfg_burst | input | BURST_W | Burst size in items |
| preq_burst | input | 1 | Peripheral burst request |
| preq_single | input | 1 | Peripheral single request |
| pclr | output | 1 | Request clear pulse to the peripheral |
| ptc | output | 1 | Terminal-count pulse on the last item |
| xfer_start | output | 1 | Start pulse to the bus master |
| xfer_len | output | BURST_W | Items in the started transfer |
| xfer_done | input | 1 | Completion pulse from the bus master |
| status | output | 2 | Channel phase |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that xfer_done arrives only once per started transfer and never in the cycle of xfer_start. They also assume that the configuration is held stable while the channel is not idle. The bench's bus model answers each start exactly once, two cycles later. Configuration changes only happen after status has returned to idle. Request lines are dropped one cycle after the start, which is still inside the transfer, so the ignore-while-busy rule is exercised without ever giving xfer_done a second time.

// File: rtl/dma_pacer_pkg.sv
package dma_pacer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_XFER = 2'd2,
      ST_DONE = 2'd3
   } pace_state_t;

   typedef enum logic [1:0] {
      DIR_P2M = 2'd0,
      DIR_M2P = 2'd1,
      DIR_M2M = 2'd2,
      DIR_RSV = 2'd3
   } pace_dir_t;
endpackage

// File: rtl/dma_pacer_remain.sv
module dma_pacer_remain
   import dma_pacer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int BURST_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [CNT_W-1:0]   load_count,
   input  logic [BURST_W-1:0] load_burst,
   input  logic [1:0]         load_dir,
   input  logic               consume,
   input  logic [BURST_W-1:0] consume_len,
   output logic [CNT_W-1:0]   remain,
   output logic [BURST_W-1:0] burst_q,
   output pace_dir_t          dir_q,
   output logic               ge_burst,
   output logic [BURST_W-1:0] short_len,
   output logic               final_step
);
   localparam int PAD_W = CNT_W - BURST_W;

   logic [CNT_W-1:0] burst_ext;
   logic [CNT_W-1:0] len_ext;

   if (BURST_W > CNT_W) begin : g_bad_width
      $error("dma_pacer_remain: BURST_W must not exceed CNT_W");
   end

   if (PAD_W == 0) begin : g_same_width
      assign burst_ext = burst_q;
      assign len_ext   = consume_len;
   end else begin : g_pad_width
      assign burst_ext = {{PAD_W{1'b0}}, burst_q};
      assign len_ext   = {{PAD_W{1'b0}}, consume_len};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain  <= '0;
         burst_q <= BURST_W'(1);
         dir_q   <= DIR_P2M;
      end else if (load) begin
         remain  <= load_count;
         // R11: zero burst size behaves as one
         burst_q <= (load_burst == '0) ? BURST_W'(1) : load_burst;
         dir_q   <= pace_dir_t'(load_dir);
      end else if (consume) begin
         remain  <= remain - len_ext;
      end
   end

   assign ge_burst   = (remain >= burst_ext);
   assign short_len  = ge_burst ? burst_q : remain[BURST_W-1:0];
   assign final_step = (remain == len_ext);

   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      consume |-> (len_ext <= remain));
endmodule

// File: rtl/dma_pacer_pick.sv
module dma_pacer_pick
   import dma_pacer_pkg::*;
#(
   parameter int BURST_W = 5
) (
   input  pace_dir_t          dir_q,
   input  logic               ge_burst,
   input  logic [BURST_W-1:0] burst_q,
   input  logic [BURST_W-1:0] short_len,
   input  logic               preq_burst,
   input  logic               preq_single,
   output logic               grant,
   output logic [BURST_W-1:0] grant_len,
   output logic               grant_clr
);
   localparam logic [BURST_W-1:0] ONE_ITEM = BURST_W'(1);

   always_comb begin
      grant     = 1'b0;
      grant_len = ONE_ITEM;
      grant_clr = 1'b0;
      unique case (dir_q)
         DIR_P2M: begin
            grant_clr = 1'b1;
            if (ge_burst) begin
               grant     = preq_burst;   // R3
               grant_len = burst_q;
            end else begin
               grant     = preq_single;  // R4
               grant_len = ONE_ITEM;
            end
         end
         DIR_M2P: begin
            grant     = preq_burst;      // R5
            grant_len = short_len;
            grant_clr = 1'b1;
         end
         DIR_M2M: begin
            grant     = 1'b1;            // R6
            grant_len = short_len;
         end
         default: begin
            grant = 1'b0;                // R10 reserved code
         end
      endcase
   end
endmodule

// File: rtl/dma_chan_pacer.sv
module dma_chan_pacer
   import dma_pacer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int BURST_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic [1:0]         cfg_dir,
   input  logic [CNT_W-1:0]   cfg_count,
   input  logic [BURST_W-1:0] cfg_burst,
   input  logic               preq_burst,
   input  logic               preq_single,
   output logic               pclr,
   output logic               ptc,
   output logic               xfer_start,
   output logic [BURST_W-1:0] xfer_len,
   input  logic               xfer_done,
   output logic [1:0]         status,
   output logic               done_pulse
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("dma_chan_pacer: CNT_W must be at least 2");
   end
   if (BURST_W < 1) begin : g_bad_burst
      $error("dma_chan_pacer: BURST_W must be at least 1");
   end

   pace_state_t        state;
   logic               start_q, clr_q, tc_q, done_q;
   logic [BURST_W-1:0] len_q;

   logic [CNT_W-1:0]   remain;
   logic [BURST_W-1:0] burst_q, short_len, grant_len;
   pace_dir_t          dir_q;
   logic               ge_burst, final_step, grant, grant_clr;
   logic               load, consume;

   assign load    = (state == ST_IDLE) && cfg_enable;
   assign consume = (state == ST_XFER) && xfer_done;

   dma_pacer_remain #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_remain (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_count (cfg_count),
      .load_burst (cfg_burst),
      .load_dir   (cfg_dir),
      .consume    (consume),
      .consume_len(len_q),
      .remain     (remain),
      .burst_q    (burst_q),
      .dir_q      (dir_q),
      .ge_burst   (ge_burst),
      .short_len  (short_len),
      .final_step (final_step)
   );

   dma_pacer_pick #(.BURST_W(BURST_W)) u_pick (
      .dir_q      (dir_q),
      .ge_burst   (ge_burst),
      .burst_q    (burst_q),
      .short_len  (short_len),
      .preq_burst (preq_burst),
      .preq_single(preq_single),
      .grant      (grant),
      .grant_len  (grant_len),
      .grant_clr  (grant_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         start_q <= 1'b0;
         clr_q   <= 1'b0;
         tc_q    <= 1'b0;
         done_q  <= 1'b0;
         len_q   <= BURST_W'(1);
      end else begin
         start_q <= 1'b0;
         clr_q   <= 1'b0;
         tc_q    <= 1'b0;
         done_q  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cfg_enable) begin
                  if (cfg_count == '0) begin
                     state  <= ST_DONE;       // R2
                     done_q <= 1'b1;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (!cfg_enable) begin
                  state <= ST_IDLE;           // R9
               end else if (grant) begin
                  state   <= ST_XFER;
                  start_q <= 1'b1;
                  clr_q   <= grant_clr;       // R7
                  len_q   <= grant_len;
               end
            end
            ST_XFER: begin
               if (xfer_done) begin
                  if (!cfg_enable) begin
                     state <= ST_IDLE;        // R9
                  end else if (final_step) begin
                     state  <= ST_DONE;       // R8
                     done_q <= 1'b1;
                     tc_q   <= (dir_q != DIR_M2M);
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            default: begin
               if (!cfg_enable) state <= ST_IDLE;
            end
         endcase
      end
   end

   assign pclr       = clr_q;
   assign ptc        = tc_q;
   assign xfer_start = start_q;
   assign xfer_len   = len_q;
   assign status     = state;
   assign done_pulse = done_q;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !(start_q || clr_q || tc_q));
   assert_single_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && dir_q == DIR_P2M && !ge_burst) |-> (len_q == BURST_W'(1)));
   assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (len_q != '0 && len_q <= burst_q));
   assert_m2m_noclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && dir_q == DIR_M2M) |-> !clr_q);
   assert_clr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |=> !clr_q);
   assert_clr_with_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |-> (start_q && state == ST_XFER));
   assert_tc_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q |-> (done_q && state == ST_DONE));
   assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER && xfer_done && !cfg_enable) |=> (state == ST_IDLE && !tc_q && !done_q));
   assert_rsv_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && dir_q == DIR_RSV) |=> !start_q);
endmodule

// File: tb/sim_dma_chan_pacer.sv
module sim_dma_chan_pacer;
   localparam int CNT_W = 16;
   localparam int BW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_enable = 1'b0;
   logic [1:0]    cfg_dir = 2'd0;
   logic [CNT_W-1:0] cfg_count = '0;
   logic [BW-1:0] cfg_burst = '0;
   logic          preq_burst = 1'b0, preq_single = 1'b0;
   logic          pclr, ptc, xfer_start, done_pulse;
   logic [BW-1:0] xfer_len;
   logic          xfer_done = 1'b0;
   logic [1:0]    status;

   int n_tests = 0, n_fail = 0, ptc_cnt = 0, done_cnt = 0;
   logic [BW:0] exp_q[$];
   logic [BW:0] e;

   always #4 clk = ~clk;

   dma_chan_pacer #(.CNT_W(CNT_W), .BURST_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dir(cfg_dir),
      .cfg_count(cfg_count), .cfg_burst(cfg_burst), .preq_burst(preq_burst),
      .preq_single(preq_single), .pclr(pclr), .ptc(ptc), .xfer_start(xfer_start),
      .xfer_len(xfer_len), .xfer_done(xfer_done), .status(status), .done_pulse(done_pulse)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor and bus model: compare each start against the scoreboard
   always begin
      @(negedge clk);
      if (xfer_start) begin
         if (exp_q.size() == 0) begin
            chk(0, "R3 R4 R5 R10 unexpected transfer, len", int'(xfer_len), 0);
         end else begin
            e = exp_q.pop_front();
            chk(xfer_len == e[BW-1:0], "R3 R4 R5 R6 R11 transfer length", int'(xfer_len), int'(e[BW-1:0]));
            chk(pclr == e[BW], "R6 R7 clear with start", int'(pclr), int'(e[BW]));
         end
         repeat (2) @(negedge clk);
         xfer_done = 1'b1;
         @(negedge clk);
         xfer_done = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (ptc) ptc_cnt++;
      if (done_pulse) done_cnt++;
   end

   task automatic enable_chan(logic [1:0] d, int cnt, int bl);
      @(negedge clk);
      cfg_dir = d; cfg_count = CNT_W'(cnt); cfg_burst = BW'(bl); cfg_enable = 1'b1;
      @(negedge clk);
   endtask

   task automatic disable_chan();
      cfg_enable = 1'b0;
      repeat (2) @(negedge clk);
      chk(status == 2'd0, "R8 idle after enable drop", int'(status), 0);
   endtask

   task automatic serve(bit b, bit s, int ln, bit clr);
      int k = 0;
      exp_q.push_back({clr, BW'(ln)});
      preq_burst = b; preq_single = s;
      do begin @(negedge clk); k++; end while (!xfer_start && k < 20);
      chk(xfer_start, "R3 R4 R5 request served", int'(xfer_start), 1);
      @(negedge clk);
      chk(status == 2'd2, "R7 busy while request still high", int'(status), 2);
      preq_burst = 1'b0; preq_single = 1'b0;
      k = 0;
      while (status == 2'd2 && k < 20) begin @(negedge clk); k++; end
   endtask

   task automatic hold_ignored(bit b, bit s, string tag);
      preq_burst = b; preq_single = s;
      repeat (6) @(negedge clk);
      chk(status == 2'd1, tag, int'(status), 1);
      preq_burst = 1'b0; preq_single = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_end(bit tc, int p0, int d0, string tag);
      @(negedge clk);
      chk(status == 2'd3, {tag, " complete status"}, int'(status), 3);
      chk(ptc_cnt - p0 == int'(tc), {tag, " terminal count pulses"}, ptc_cnt - p0, int'(tc));
      chk(done_cnt - d0 == 1, {tag, " done pulses"}, done_cnt - d0, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "R1 watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int p0, d0, k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 and R10 reset state
      chk(status == 2'd0, "R1 R10 reset status", int'(status), 0);
      chk(!xfer_start && !pclr && !ptc && !done_pulse, "R1 reset outputs low", 1, 0);

      // peripheral to memory, 10 items, burst 4
      enable_chan(2'd0, 10, 4);
      chk(status == 2'd1, "R2 waiting after enable", int'(status), 1);
      hold_ignored(0, 1, "R3 single ignored above burst");
      serve(1, 0, 4, 1);
      serve(1, 1, 4, 1);              // R3 both lines high: burst taken
      hold_ignored(1, 0, "R4 burst ignored below burst size");
      p0 = ptc_cnt; d0 = done_cnt;
      serve(0, 1, 1, 1);
      serve(1, 1, 1, 1);              // R4 both high: single taken
      expect_end(1, p0, d0, "R8 p2m");
      disable_chan();

      // R3 remaining equals burst size
      enable_chan(2'd0, 8, 4);
      p0 = ptc_cnt; d0 = done_cnt;
      serve(1, 0, 4, 1);
      serve(1, 0, 4, 1);
      expect_end(1, p0, d0, "R3 exact burst");
      disable_chan();

      // R5 memory to peripheral, short last burst
      enable_chan(2'd1, 10, 4);
      hold_ignored(0, 1, "R5 single ignored");
      p0 = ptc_cnt; d0 = done_cnt;
      serve(1, 0, 4, 1);
      serve(1, 0, 4, 1);
      serve(1, 1, 2, 1);
      expect_end(1, p0, d0, "R5 m2p");
      disable_chan();

      // R5 burst size one
      enable_chan(2'd1, 3, 1);
      p0 = ptc_cnt; d0 = done_cnt;
      serve(1, 0, 1, 1);
      serve(1, 0, 1, 1);
      serve(1, 0, 1, 1);
      expect_end(1, p0, d0, "R5 burst one");
      disable_chan();

      // R6 memory to memory
      exp_q.push_back({1'b0, BW'(4)});
      exp_q.push_back({1'b0, BW'(4)});
      exp_q.push_back({1'b0, BW'(1)});
      p0 = ptc_cnt; d0 = done_cnt;
      enable_chan(2'd2, 9, 4);
      k = 0;
      while (status != 2'd3 && k < 200) begin @(negedge clk); k++; end
      chk(exp_q.size() == 0, "R6 all transfers issued", exp_q.size(), 0);
      expect_end(0, p0, d0, "R6 m2m");
      disable_chan();

      // R9 disable during transfer
      exp_q.push_back({1'b0, BW'(4)});
      p0 = ptc_cnt; d0 = done_cnt;
      enable_chan(2'd2, 20, 4);
      k = 0;
      while (!xfer_start && k < 20) begin @(negedge clk); k++; end
      cfg_enable = 1'b0;
      repeat (8) @(negedge clk);
      chk(status == 2'd0, "R9 idle after abort", int'(status), 0);
      chk(exp_q.size() == 0, "R9 in-flight transfer finished", exp_q.size(), 0);
      chk(ptc_cnt == p0 && done_cnt == d0, "R9 no tc or done on abort", ptc_cnt - p0 + done_cnt - d0, 0);

      // R9 disable while waiting
      enable_chan(2'd0, 5, 4);
      cfg_enable = 1'b0;
      @(negedge clk);
      chk(status == 2'd0, "R9 idle from waiting", int'(status), 0);

      // R2 zero count
      d0 = done_cnt; p0 = ptc_cnt;
      enable_chan(2'd1, 0, 4);
      @(negedge clk);
      chk(status == 2'd3, "R2 zero count completes", int'(status), 3);
      chk(done_cnt - d0 == 1, "R2 zero count done pulse", done_cnt - d0, 1);
      chk(ptc_cnt == p0, "R2 zero count no tc", ptc_cnt - p0, 0);
      disable_chan();

      // R11 burst zero acts as one
      enable_chan(2'd1, 2, 0);
      p0 = ptc_cnt; d0 = done_cnt;
      serve(1, 0, 1, 1);
      serve(1, 0, 1, 1);
      expect_end(1, p0, d0, "R11 zero burst");
      disable_chan();

      // R10 reserved direction
      enable_chan(2'd3, 4, 4);
      hold_ignored(1, 1, "R10 reserved direction never starts");
      disable_chan();

      repeat (4) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule